// File: doc/BRIEF.md
# Interrupt Source Presented/Queued State Bank

This block holds a two-bit state for each of a bank of interrupt sources: P (an event has been presented to the router and not yet retired) and Q (another event arrived while P was set). Masking, in-flight tracking and coalescing of events all live in these two bits. Events from edge (message-signalled) sources arrive on a trigger port. Level sources are watched through a vector of level lines. When a source moves from idle to presented, a one-cycle notification pulse goes out toward the downstream router.

Software-side agents reach the state through an access port. The port carries a source index, a read/write flag and an offset. Four bits of the offset, bits [11:8], select the operation: read state, force the state to any of the four values, a load-type end-of-interrupt, or a store-type end-of-interrupt. Every load returns the state held before the operation. An end-of-interrupt on an edge source that had Q set raises a new notification, so a coalesced second event is not lost. A retrigger is done as a force to 11 followed by an end-of-interrupt. An optional offset correction mode serves agents that place the operation code four bits too low.

Top module: `pq_source_bank`

## Requirements
- R1: After reset every source holds PQ=01 (masked), no notification is asserted and rd_vld is low.
- R2: A load with code 4 (GET) returns the state in rd_data, with P in bit 1, Q in bit 0 and the upper bits zero. The state does not change. rd_vld and rd_data are valid in the cycle after the access.
- R3: A load with code 12, 13, 14 or 15 sets PQ to the low two bits of the code (00, 01, 10, 11) and returns the previous PQ.
- R4: An event on an edge source moves PQ 00 to 10 and raises one notification. It moves 10 to 11 with no notification, and leaves 11 unchanged.
- R5: A source at PQ=01 ignores events and emits nothing.
- R6: A load with code 0 is an end-of-interrupt, and it returns the old PQ. On an edge source it maps 10 to 00, maps 11 to 10 with a notification, and leaves 00 and 01 unchanged.
- R7: A write with code 0 performs the same end-of-interrupt transition and produces no read data. Writes with any other code change nothing.
- R8: Sources whose bit is set in LEVEL_MASK take events only from their level line and ignore the trigger port. Their end-of-interrupt clears a set P to 00 whatever Q holds, and a line that is still high fires again at once.
- R9: When an access and an event reach the same source in one cycle, the access is applied first and the event then acts on its result. The returned data is the state before both.
- R10: A load to a source index of NUM_SRC or above, or with an undefined code, returns all ones, which marks an invalid state. It changes no source.
- R11: With ofs_shift_en high, the offset is ORed with itself shifted left by 4 before the code in bits [11:8] is decoded.
- R12: Notifications are single-cycle pulses, one bit per source, registered in the cycle after their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_vld | input | 1 | Edge event present this cycle |
| trig_id | input | ID_W | Source index of the edge event |
| lvl_in | input | NUM_SRC | Level lines of level-mode sources |
| acc_vld | input | 1 | Access request valid |
| acc_wr | input | 1 | Access is a write (store) |
| acc_id | input | ID_W+1 | Source index of the access |
| acc_ofs | input | OFS_W | Access offset, operation code in bits [11:8] |
| ofs_shift_en | input | 1 | Enables the offset correction mode |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | DATA_W | Old PQ value, or all ones when invalid |
| notify | output | NUM_SRC | One-cycle notification pulse per source |

## Verification
Every result comes from a single register stage. The read data, the new PQ state and any notification caused by an access or event sampled at one clock edge all become visible just after that edge. The bench drives each step on the falling edge and samples one time unit after the next rising edge, so each check lands in the cycle its result is due. The effect of a state change is read back through a GET in the following step, and that GET returns its result one cycle later in the same way.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GET,
        OP_LDEOI,
        OP_STEOI,
        OP_SET,
        OP_BAD
    } pq_op_e;

    localparam logic [1:0] PQ_OFF = 2'b01;

    typedef struct packed {
        logic [1:0] pq;
        logic       ntf;
    } cell_st_t;

endpackage

// File: rtl/pq_acc_decode.sv
module pq_acc_decode
    import pq_src_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic             acc_vld,
    input  logic             acc_wr,
    input  logic [OFS_W-1:0] acc_ofs,
    input  logic             ofs_shift_en,
    output pq_op_e           op,
    output logic [1:0]       set_val
);
    localparam int CODE_LSB = OFS_W - 4;

    logic [OFS_W-1:0] eff_ofs;
    logic [3:0]       code;

    always_comb begin
        eff_ofs = ofs_shift_en ? (acc_ofs | (acc_ofs << 4)) : acc_ofs;
        code    = eff_ofs[CODE_LSB +: 4];
        set_val = code[1:0];
        op      = OP_NONE;
        if (acc_vld) begin
            if (acc_wr) begin
                op = (code == 4'h0) ? OP_STEOI : OP_NONE;
            end else begin
                unique case (code)
                    4'h0:                      op = OP_LDEOI;
                    4'h4:                      op = OP_GET;
                    4'hC, 4'hD, 4'hE, 4'hF:    op = OP_SET;
                    default:                   op = OP_BAD;
                endcase
            end
        end
    end
endmodule

// File: rtl/pq_cell.sv
module pq_cell
    import pq_src_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  pq_op_e     op,
    input  logic [1:0] set_val,
    input  logic       edge_ev,
    input  logic       lvl,
    output logic [1:0] pq_o,
    output logic       ntf_o
);
    cell_st_t st_d, st_q;
    logic     ev;

    always_comb begin
        st_d     = st_q;
        st_d.ntf = 1'b0;
        if (hit) begin
            unique case (op)
                OP_SET: st_d.pq = set_val;
                OP_LDEOI, OP_STEOI: begin
                    if (IS_LEVEL) begin
                        if (st_q.pq[1]) st_d.pq = 2'b00;
                    end else if (st_q.pq == 2'b10) begin
                        st_d.pq = 2'b00;
                    end else if (st_q.pq == 2'b11) begin
                        st_d.pq  = 2'b10;
                        st_d.ntf = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        ev = IS_LEVEL ? lvl : edge_ev;
        if (ev) begin
            if (st_d.pq == 2'b00) begin
                st_d.pq  = 2'b10;
                st_d.ntf = 1'b1;
            end else if (st_d.pq == 2'b10 && !IS_LEVEL) begin
                st_d.pq = 2'b11;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pq  <= PQ_OFF;
            st_q.ntf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pq_o  = st_q.pq;
    assign ntf_o = st_q.ntf;
endmodule

// File: rtl/pq_source_bank.sv
module pq_source_bank
    import pq_src_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 OFS_W      = 12,
    parameter int                 DATA_W     = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
    localparam int                ID_W       = $clog2(NUM_SRC),
    localparam int                AID_W      = ID_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_vld,
    input  logic [ID_W-1:0]    trig_id,
    input  logic [NUM_SRC-1:0] lvl_in,
    input  logic               acc_vld,
    input  logic               acc_wr,
    input  logic [AID_W-1:0]   acc_id,
    input  logic [OFS_W-1:0]   acc_ofs,
    input  logic               ofs_shift_en,
    output logic               rd_vld,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_SRC-1:0] notify
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    pq_op_e     op;
    logic [1:0] set_val;
    logic [1:0] pq_all [NUM_SRC];
    logic       id_ok;
    rd_st_t     rd_d, rd_q;

    pq_acc_decode #(.OFS_W(OFS_W)) u_dec (
        .acc_vld      (acc_vld),
        .acc_wr       (acc_wr),
        .acc_ofs      (acc_ofs),
        .ofs_shift_en (ofs_shift_en),
        .op           (op),
        .set_val      (set_val)
    );

    assign id_ok = (acc_id < AID_W'(NUM_SRC));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic hit_i;
        logic ev_i;
        assign hit_i = id_ok && (acc_id == AID_W'(i));
        assign ev_i  = trig_vld && (trig_id == ID_W'(i));
        pq_cell #(.IS_LEVEL(LEVEL_MASK[i])) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit_i),
            .op      (op),
            .set_val (set_val),
            .edge_ev (ev_i),
            .lvl     (lvl_in[i]),
            .pq_o    (pq_all[i]),
            .ntf_o   (notify[i])
        );
    end

    always_comb begin
        rd_d.vld  = acc_vld && !acc_wr;
        rd_d.data = '1;
        if (id_ok && op != OP_BAD) begin
            rd_d.data = {{(DATA_W-2){1'b0}}, pq_all[acc_id[ID_W-1:0]]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_vld  = rd_q.vld;
    assign rd_data = rd_q.data;
endmodule

// File: rtl/pq_source_bank_chk.sv
module pq_source_bank_chk #(
    parameter int                 NUM_SRC    = 8,
    parameter int                 OFS_W      = 12,
    parameter int                 DATA_W     = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
    localparam int                ID_W       = $clog2(NUM_SRC),
    localparam int                AID_W      = ID_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trig_vld,
    input logic [ID_W-1:0]    trig_id,
    input logic [NUM_SRC-1:0] lvl_in,
    input logic               acc_vld,
    input logic               acc_wr,
    input logic [AID_W-1:0]   acc_id,
    input logic [OFS_W-1:0]   acc_ofs,
    input logic               ofs_shift_en,
    input logic               rd_vld,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_SRC-1:0] notify
);
    // R2
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(acc_vld && !acc_wr));

    // R7
    store_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr) |=> !rd_vld);

    // R10
    bad_id_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_wr && acc_id >= AID_W'(NUM_SRC)) |=> (rd_data == '1));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R12
        ntf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            notify[i] |-> $past((acc_vld && acc_id == AID_W'(i))
                                || (trig_vld && trig_id == ID_W'(i)) || lvl_in[i]));
        if (!LEVEL_MASK[i]) begin : g_edge
            // R4
            ntf_coalesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (notify[i] && $past(notify[i])) |-> $past(acc_vld && acc_id == AID_W'(i)));
        end
    end
endmodule

bind pq_source_bank pq_source_bank_chk #(
    .NUM_SRC    (NUM_SRC),
    .OFS_W      (OFS_W),
    .DATA_W     (DATA_W),
    .LEVEL_MASK (LEVEL_MASK)
) u_chk (.*);

// File: tb/pq_source_bank_tb.sv
module pq_source_bank_tb;
    localparam int NSRC  = 8;
    localparam int NSTEP = 36;

    typedef struct packed {
        logic        sh;
        logic        trg;
        logic [2:0]  tid;
        logic [7:0]  lvl;
        logic        av;
        logic        wr;
        logic [3:0]  aid;
        logic [11:0] ofs;
        logic        erv;
        logic [7:0]  erd;
        logic [7:0]  entf;
    } vec_t;

    // sh trg tid lvl av wr aid ofs erv erd entf
    localparam vec_t TBL [NSTEP] = '{
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h01,8'h00}, // 0 R2 GET masked
        '{1'b0,1'b1,3'd1,8'h00,1'b0,1'b0,4'd0,12'h000,1'b0,8'h00,8'h00}, // 1 R5 trig masked
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h01,8'h00}, // 2 R5 still 01
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'hC00,1'b1,8'h01,8'h00}, // 3 R3 set 00
        '{1'b0,1'b1,3'd1,8'h00,1'b0,1'b0,4'd0,12'h000,1'b0,8'h00,8'h02}, // 4 R4 00->10
        '{1'b0,1'b1,3'd1,8'h00,1'b0,1'b0,4'd0,12'h000,1'b0,8'h00,8'h00}, // 5 R4 10->11
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h03,8'h00}, // 6 R4 read 11
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h000,1'b1,8'h03,8'h02}, // 7 R6 eoi 11
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h000,1'b1,8'h02,8'h00}, // 8 R6 eoi 10
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h00,8'h00}, // 9 R6 now 00
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'hF00,1'b1,8'h00,8'h00}, // 10 R3 set 11
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b1,4'd1,12'h000,1'b0,8'h00,8'h02}, // 11 R7 store eoi
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b1,4'd1,12'hC00,1'b0,8'h00,8'h00}, // 12 R7 write other
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h02,8'h00}, // 13 R7 still 10
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'hD00,1'b1,8'h02,8'h00}, // 14 R3 set 01
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h000,1'b1,8'h01,8'h00}, // 15 R6 eoi masked
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h01,8'h00}, // 16 R6 stays 01
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd9,12'h400,1'b1,8'hFF,8'h00}, // 17 R10 bad id
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h100,1'b1,8'hFF,8'h00}, // 18 R10 bad code
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h01,8'h00}, // 19 R10 unchanged
        '{1'b0,1'b1,3'd1,8'h00,1'b1,1'b0,4'd1,12'hC00,1'b1,8'h01,8'h02}, // 20 R9 set+trig
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd1,12'h400,1'b1,8'h02,8'h00}, // 21 R9 now 10
        '{1'b0,1'b1,3'd4,8'h00,1'b1,1'b0,4'd4,12'hC00,1'b1,8'h01,8'h00}, // 22 R8 trig port ignored
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd4,12'h400,1'b1,8'h00,8'h00}, // 23 R8 read 00
        '{1'b0,1'b0,3'd0,8'h10,1'b0,1'b0,4'd0,12'h000,1'b0,8'h00,8'h10}, // 24 R8 line fires
        '{1'b0,1'b0,3'd0,8'h10,1'b1,1'b0,4'd4,12'h400,1'b1,8'h02,8'h00}, // 25 R8 held 10
        '{1'b0,1'b0,3'd0,8'h10,1'b1,1'b0,4'd4,12'h000,1'b1,8'h02,8'h10}, // 26 R8 eoi refire
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd4,12'hF00,1'b1,8'h02,8'h00}, // 27 R8 set 11
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd4,12'h000,1'b1,8'h03,8'h00}, // 28 R8 eoi no Q
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd4,12'h400,1'b1,8'h00,8'h00}, // 29 R8 now 00
        '{1'b1,1'b0,3'd0,8'h00,1'b1,1'b0,4'd2,12'h0C0,1'b1,8'h01,8'h00}, // 30 R11 -> set 00
        '{1'b1,1'b0,3'd0,8'h00,1'b1,1'b0,4'd2,12'h040,1'b1,8'h00,8'h00}, // 31 R11 -> GET
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd2,12'h0D0,1'b1,8'h00,8'h00}, // 32 R11 off -> eoi
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,4'd2,12'h400,1'b1,8'h00,8'h00}, // 33 R11 still 00
        '{1'b0,1'b1,3'd2,8'h00,1'b0,1'b0,4'd0,12'h000,1'b0,8'h00,8'h04}, // 34 R12 pulse
        '{1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,4'd0,12'h000,1'b0,8'h00,8'h00}  // 35 R12 pulse ends
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trig_vld;
    logic [2:0]  trig_id;
    logic [7:0]  lvl_in;
    logic        acc_vld;
    logic        acc_wr;
    logic [3:0]  acc_id;
    logic [11:0] acc_ofs;
    logic        ofs_shift_en;
    logic        rd_vld;
    logic [7:0]  rd_data;
    logic [7:0]  notify;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    string step_tag [NSTEP];

    always #10 clk = ~clk;

    pq_source_bank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_vld     (trig_vld),
        .trig_id      (trig_id),
        .lvl_in       (lvl_in),
        .acc_vld      (acc_vld),
        .acc_wr       (acc_wr),
        .acc_id       (acc_id),
        .acc_ofs      (acc_ofs),
        .ofs_shift_en (ofs_shift_en),
        .rd_vld       (rd_vld),
        .rd_data      (rd_data),
        .notify       (notify)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        trig_vld = 1'b0; trig_id = '0; lvl_in = '0; acc_vld = 1'b0;
        acc_wr = 1'b0; acc_id = '0; acc_ofs = '0; ofs_shift_en = 1'b0;
    endtask

    initial begin
        step_tag = '{"R2","R5","R5","R3","R4","R4","R4","R6","R6","R6",
                     "R3","R7","R7","R7","R3","R6","R6","R10","R10","R10",
                     "R9","R9","R8","R8","R8","R8","R8","R8","R8","R8",
                     "R11","R11","R11","R11","R12","R12"};
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet in reset
        check("R1", "rd_vld in reset", 16'(rd_vld), 16'h0);
        check("R1", "notify in reset", 16'(notify), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every source reads back masked
        for (int s = 0; s < NSRC; s++) begin
            @(negedge clk);
            acc_vld = 1'b1; acc_id = 4'(s); acc_ofs = 12'h400;
            @(posedge clk);
            #1;
            check("R1", "reset PQ", 16'(rd_data), 16'h01);
            check("R1", "reset notify", 16'(notify), 16'h0);
        end
        for (int k = 0; k < NSTEP; k++) begin
            @(negedge clk);
            ofs_shift_en = TBL[k].sh;
            trig_vld     = TBL[k].trg;
            trig_id      = TBL[k].tid;
            lvl_in       = TBL[k].lvl;
            acc_vld      = TBL[k].av;
            acc_wr       = TBL[k].wr;
            acc_id       = TBL[k].aid;
            acc_ofs      = TBL[k].ofs;
            @(posedge clk);
            #1;
            check(step_tag[k], $sformatf("step %0d notify", k), 16'(notify), 16'(TBL[k].entf));
            check(step_tag[k], $sformatf("step %0d rd_vld", k), 16'(rd_vld), 16'(TBL[k].erv));
            if (TBL[k].erv)
                check(step_tag[k], $sformatf("step %0d rd_data", k), 16'(rd_data), 16'(TBL[k].erd));
        end
        @(negedge clk);
        idle();
        @(posedge clk);
        #1;
        // R12: nothing pending once inputs go idle
        check("R12", "idle notify", 16'(notify), 16'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule